// File: doc/BRIEF.md
# Prioritized Memory Protection Region Checker

This block sits next to a memory bus and decides, in the same cycle, whether an access may proceed. It holds a configurable number of protection regions (eight by default). Each region has a base address, a power-of-two size, an enable, eight subregion-disable bits, a two-bit permission code and an execute-never flag. For every access the checker reports allow or fault, whether a region matched, and which region matched.

When regions overlap, the region with the higher index wins. A disabled subregion is treated as not part of its region, so the lookup falls through to lower-numbered regions. An address that matches no region is allowed only when the background map is switched on and the access is privileged. When the checker as a whole is switched off, every access is allowed. Regions and the two global switches are programmed through a simple write port. A write takes effect from the next clock edge.

Top module: `prot_region_checker`

## Requirements
- R1: After reset the checker is switched off and every region is disabled. Every access then reports acc_allow=1, acc_hit=0 and acc_region=0.
- R2: While the global enable is 0, every access reports acc_allow=1, acc_hit=0 and acc_region=0, whatever the region settings are.
- R3: A region of size code s covers the 2^s bytes that start at its base with the low s bits cleared. The low s bits of the written base are ignored. A written size code below 5 is stored as 5, and a code above 32 is stored as 32 (the whole space).
- R4: When several enabled regions match an address, acc_region reports the highest-numbered one, and that region's permissions apply.
- R5: Each region is split into eight equal subregions. The subregion number is address bits [s-1:s-3], and bit k of the disable field removes subregion k. An access that falls in a removed subregion is resolved by the lower-numbered regions, or by the background rules.
- R6: The permission code works as follows. 0 denies everything. 1 allows privileged reads and writes and denies unprivileged accesses. 2 allows reads at either privilege level and denies writes. 3 allows everything.
- R7: The access kind is coded 0=read, 1=write, 2 or 3=instruction fetch. A fetch is judged like a read, except that it always faults when the matched region has execute-never set.
- R8: When the checker is on and no region matches, acc_hit=0 and acc_region=0. A privileged access is then allowed only when the background map is enabled, and an unprivileged access always faults.
- R9: A region or control write is applied at the clock edge. An access presented in the same cycle as the write is judged with the old settings, and accesses from the next cycle on are judged with the new settings.
- R10: A region whose enable is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Writes the two global switches |
| ctl_enable | input | 1 | Global checker enable |
| ctl_bg_en | input | 1 | Privileged background map enable |
| cfg_we | input | 1 | Writes one region |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 32 | Region base address |
| cfg_size_log2 | input | 6 | Region size as log2 of bytes (clamped to 5..32) |
| cfg_en | input | 1 | Region enable |
| cfg_sub_off | input | 8 | Subregion disable bits |
| cfg_ap | input | 2 | Permission code |
| cfg_xn | input | 1 | Execute-never |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 fetch |
| acc_allow | output | 1 | Access allowed |
| acc_hit | output | 1 | A region matched |
| acc_region | output | 3 | Number of the winning region, 0 when no region matched |

## Verification
A region write and a lookup can happen in the same cycle, because the lookup is combinational and reads the stored settings while the write port updates them. The bench presents an unprivileged access to an unmapped address in the same low phase as a write that maps that address with full access. It samples once before the edge, where a fault is expected, and once after the edge, where the access is expected to be allowed. Disabling a region that is matching an address is checked in the same way. In that case the expected result switches at the edge to the lower-priority region or to the background rule.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    AK_READ      = 2'd0,
    AK_WRITE     = 2'd1,
    AK_FETCH     = 2'd2,
    AK_FETCH_ALT = 2'd3
  } acc_kind_e;

  localparam logic [1:0] AP_NONE      = 2'd0;
  localparam logic [1:0] AP_PRIV_RW   = 2'd1;
  localparam logic [1:0] AP_READ_ONLY = 2'd2;
  localparam logic [1:0] AP_FULL      = 2'd3;

  localparam int SUB_LOG2   = 3;
  localparam int SIZE_MIN   = 5;
  localparam int SIZE_CODE_W = 6;

endpackage

// File: rtl/prc_region_match.sv
module prc_region_match
  import prc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-1:0]          base,
  input  logic [SIZE_CODE_W-1:0]     size_log2,
  input  logic                       en,
  input  logic [(1<<SUB_LOG2)-1:0]   sub_off,
  output logic                       match
);

  logic [ADDR_W-1:0]   keep_mask;
  logic [ADDR_W-1:0]   diff;
  logic [SUB_LOG2-1:0] sub_idx;

  always_comb begin
    if (size_log2 >= SIZE_CODE_W'(ADDR_W)) begin
      keep_mask = '0;
    end else begin
      keep_mask = {ADDR_W{1'b1}} << size_log2;
    end
    diff    = (addr ^ base) & keep_mask;
    sub_idx = SUB_LOG2'(addr >> (size_log2 - SIZE_CODE_W'(SUB_LOG2)));
    match   = en && (diff == '0) && !sub_off[sub_idx];
  end

endmodule

// File: rtl/prc_prio_pick.sv
module prc_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prc_perm_eval.sv
module prc_perm_eval
  import prc_pkg::*;
(
  input  logic [1:0] ap,
  input  logic       xn,
  input  logic       priv,
  input  logic [1:0] kind,
  output logic       ok
);

  logic is_write;
  logic is_fetch;
  logic code_ok;

  always_comb begin
    is_write = (kind == AK_WRITE);
    is_fetch = (kind == AK_FETCH) || (kind == AK_FETCH_ALT);
    case (ap)
      AP_NONE:      code_ok = 1'b0;
      AP_PRIV_RW:   code_ok = priv;
      AP_READ_ONLY: code_ok = !is_write;
      default:      code_ok = 1'b1;
    endcase
    ok = code_ok && !(is_fetch && xn);
  end

endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int SUB_N      = 1 << SUB_LOG2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic                   ctl_enable,
  input  logic                   ctl_bg_en,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [SIZE_CODE_W-1:0] cfg_size_log2,
  input  logic                   cfg_en,
  input  logic [SUB_N-1:0]       cfg_sub_off,
  input  logic [1:0]             cfg_ap,
  input  logic                   cfg_xn,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_priv,
  input  logic [1:0]             acc_kind,
  output logic                   acc_allow,
  output logic                   acc_hit,
  output logic [IDX_W-1:0]       acc_region
);

  // reset synchronizer: assert asynchronously, release on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  // global control
  logic glob_en_q, glob_en_d;
  logic bg_en_q, bg_en_d;

  always_comb begin
    glob_en_d = glob_en_q;
    bg_en_d   = bg_en_q;
    if (ctl_we) begin
      glob_en_d = ctl_enable;
      bg_en_d   = ctl_bg_en;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      glob_en_q <= 1'b0;
      bg_en_q   <= 1'b0;
    end else if (ctl_we) begin
      glob_en_q <= glob_en_d;
      bg_en_q   <= bg_en_d;
    end
  end

  // region storage
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      base_q;
  logic [NUM_REGIONS-1:0][SIZE_CODE_W-1:0] size_q;
  logic [NUM_REGIONS-1:0]                  en_q;
  logic [NUM_REGIONS-1:0][SUB_N-1:0]       sub_off_q;
  logic [NUM_REGIONS-1:0][1:0]             ap_q;
  logic [NUM_REGIONS-1:0]                  xn_q;
  logic [NUM_REGIONS-1:0]                  region_hits;
  logic [SIZE_CODE_W-1:0]                  size_clamped;

  always_comb begin
    if (cfg_size_log2 < SIZE_CODE_W'(SIZE_MIN)) begin
      size_clamped = SIZE_CODE_W'(SIZE_MIN);
    end else if (cfg_size_log2 > SIZE_CODE_W'(ADDR_W)) begin
      size_clamped = SIZE_CODE_W'(ADDR_W);
    end else begin
      size_clamped = cfg_size_log2;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic                   upd_en;
    logic [ADDR_W-1:0]      base_d;
    logic [SIZE_CODE_W-1:0] size_d;
    logic                   en_d;
    logic [SUB_N-1:0]       sub_off_d;
    logic [1:0]             ap_d;
    logic                   xn_d;

    always_comb begin
      upd_en    = cfg_we && (cfg_idx == IDX_W'(g));
      base_d    = cfg_base;
      size_d    = size_clamped;
      en_d      = cfg_en;
      sub_off_d = cfg_sub_off;
      ap_d      = cfg_ap;
      xn_d      = cfg_xn;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
        base_q[g]    <= '0;
        size_q[g]    <= SIZE_CODE_W'(SIZE_MIN);
        en_q[g]      <= 1'b0;
        sub_off_q[g] <= '0;
        ap_q[g]      <= AP_NONE;
        xn_q[g]      <= 1'b0;
      end else if (upd_en) begin
        base_q[g]    <= base_d;
        size_q[g]    <= size_d;
        en_q[g]      <= en_d;
        sub_off_q[g] <= sub_off_d;
        ap_q[g]      <= ap_d;
        xn_q[g]      <= xn_d;
      end
    end

    prc_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr      (acc_addr),
      .base      (base_q[g]),
      .size_log2 (size_q[g]),
      .en        (en_q[g]),
      .sub_off   (sub_off_q[g]),
      .match     (region_hits[g])
    );
  end

  // priority resolution and permission evaluation
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             perm_ok;

  prc_prio_pick #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .hits (region_hits),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  prc_perm_eval u_perm (
    .ap   (ap_q[pick_idx]),
    .xn   (xn_q[pick_idx]),
    .priv (acc_priv),
    .kind (acc_kind),
    .ok   (perm_ok)
  );

  always_comb begin
    if (!glob_en_q) begin
      acc_allow  = 1'b1;
      acc_hit    = 1'b0;
      acc_region = '0;
    end else if (pick_any) begin
      acc_allow  = perm_ok;
      acc_hit    = 1'b1;
      acc_region = pick_idx;
    end else begin
      acc_allow  = bg_en_q && acc_priv;
      acc_hit    = 1'b0;
      acc_region = '0;
    end
  end

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        glob_en_q,
  input logic                        cfg_we,
  input logic                        cfg_en,
  input logic [IDX_W-1:0]            cfg_idx,
  input logic                        acc_priv,
  input logic [1:0]                  acc_kind,
  input logic                        acc_allow,
  input logic                        acc_hit,
  input logic [IDX_W-1:0]            acc_region,
  input logic [NUM_REGIONS-1:0][1:0] ap_q,
  input logic [NUM_REGIONS-1:0]      xn_q
);

  AST_OFF_PASSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_q |-> (acc_allow && !acc_hit && acc_region == '0)); // R2

  AST_MISS_REGION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> (acc_region == '0)); // R8

  AST_UNPRIV_MISS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en_q && !acc_hit && !acc_priv) |-> !acc_allow); // R8

  AST_XN_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_kind[1] && xn_q[acc_region]) |-> !acc_allow); // R7

  AST_RO_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_kind == 2'd1 && ap_q[acc_region] == 2'd2) |-> !acc_allow); // R6

  AST_DISABLED_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_en) |=> !(acc_hit && acc_region == $past(cfg_idx))); // R10

endmodule

bind prot_region_checker prc_checker #(
  .NUM_REGIONS (NUM_REGIONS),
  .IDX_W       (IDX_W)
) u_prc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .glob_en_q  (glob_en_q),
  .cfg_we     (cfg_we),
  .cfg_en     (cfg_en),
  .cfg_idx    (cfg_idx),
  .acc_priv   (acc_priv),
  .acc_kind   (acc_kind),
  .acc_allow  (acc_allow),
  .acc_hit    (acc_hit),
  .acc_region (acc_region),
  .ap_q       (ap_q),
  .xn_q       (xn_q)
);

// File: tb/prot_region_checker_bench.sv
module prot_region_checker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ctl_we, ctl_enable, ctl_bg_en;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [5:0]  cfg_size_log2;
  logic        cfg_en;
  logic [7:0]  cfg_sub_off;
  logic [1:0]  cfg_ap;
  logic        cfg_xn;
  logic [31:0] acc_addr;
  logic        acc_priv;
  logic [1:0]  acc_kind;
  logic        acc_allow, acc_hit;
  logic [2:0]  acc_region;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_base [8];
  int          m_size [8];
  bit          m_en   [8];
  logic [7:0]  m_srd  [8];
  logic [1:0]  m_ap   [8];
  bit          m_xn   [8];
  bit          m_glob, m_bg;

  prot_region_checker u_prot_region_checker (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_bg_en(ctl_bg_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size_log2(cfg_size_log2), .cfg_en(cfg_en), .cfg_sub_off(cfg_sub_off),
    .cfg_ap(cfg_ap), .cfg_xn(cfg_xn),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
    .acc_allow(acc_allow), .acc_hit(acc_hit), .acc_region(acc_region)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input logic [31:0] a, input bit pv, input logic [1:0] k,
                                output bit al, output bit ht, output logic [2:0] rg);
    longint unsigned span, lo, sub;
    bit code_ok;
    al = 1'b1; ht = 1'b0; rg = 3'd0;
    if (!m_glob) return;
    for (int r = 7; r >= 0; r--) begin
      if (!ht && m_en[r]) begin
        span = 64'd1 << m_size[r];
        lo   = (longint'(m_base[r]) / span) * span;
        if (longint'(a) >= lo && longint'(a) < lo + span) begin
          sub = (longint'(a) - lo) / (span / 8);
          if (!m_srd[r][sub]) begin
            ht = 1'b1;
            rg = 3'(r);
          end
        end
      end
    end
    if (ht) begin
      case (m_ap[rg])
        2'd0: code_ok = 1'b0;
        2'd1: code_ok = pv;
        2'd2: code_ok = (k != 2'd1);
        default: code_ok = 1'b1;
      endcase
      al = code_ok && !(k >= 2'd2 && m_xn[rg]);
    end else begin
      al = m_bg && pv;
    end
  endfunction

  task automatic apply_region(int i, logic [31:0] b, int s, bit e, logic [7:0] srd,
                              logic [1:0] ap, bit xn);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = b; cfg_size_log2 = 6'(s);
    cfg_en = e; cfg_sub_off = srd; cfg_ap = ap; cfg_xn = xn;
  endtask

  task automatic commit_region(int i, logic [31:0] b, int s, bit e, logic [7:0] srd,
                               logic [1:0] ap, bit xn);
    m_base[i] = b;
    m_size[i] = (s < 5) ? 5 : ((s > 32) ? 32 : s);
    m_en[i] = e; m_srd[i] = srd; m_ap[i] = ap; m_xn[i] = xn;
  endtask

  task automatic wr_region(int i, logic [31:0] b, int s, bit e, logic [7:0] srd,
                           logic [1:0] ap, bit xn);
    @(negedge clk);
    apply_region(i, b, s, e, srd, ap, xn);
    @(negedge clk);
    cfg_we = 1'b0;
    commit_region(i, b, s, e, srd, ap, xn);
  endtask

  task automatic wr_ctl(bit en, bit bg);
    @(negedge clk);
    ctl_we = 1'b1; ctl_enable = en; ctl_bg_en = bg;
    @(negedge clk);
    ctl_we = 1'b0;
    m_glob = en; m_bg = bg;
  endtask

  task automatic probe(string req, logic [31:0] a, bit pv, logic [1:0] k);
    bit al, ht;
    logic [2:0] rg;
    acc_addr = a; acc_priv = pv; acc_kind = k;
    #1;
    model(a, pv, k, al, ht, rg);
    checks++;
    if ({acc_allow, acc_hit, acc_region} !== {al, ht, rg}) begin
      errors++;
      $display("FAIL %s addr=%h priv=%0d kind=%0d: actual allow=%0d hit=%0d region=%0d expected allow=%0d hit=%0d region=%0d",
               req, a, pv, k, acc_allow, acc_hit, acc_region, al, ht, rg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    ctl_we = 0; ctl_enable = 0; ctl_bg_en = 0;
    cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_size_log2 = 0; cfg_en = 0;
    cfg_sub_off = 0; cfg_ap = 0; cfg_xn = 0;
    acc_addr = 0; acc_priv = 0; acc_kind = 0;
    m_glob = 0; m_bg = 0;
    for (int i = 0; i < 8; i++) commit_region(i, 32'h0, 5, 0, 8'h0, 2'd0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state allows everything
    probe("R1", 32'h1234_5678, 0, 2'd1);
    probe("R1", 32'h0000_0000, 1, 2'd2);

    // R3 / R8: single region, background off
    wr_ctl(1, 0);
    wr_region(0, 32'h2000_0000, 16, 1, 8'h00, 2'd3, 0);
    probe("R3", 32'h2000_FFFF, 0, 2'd1);
    probe("R8", 32'h2001_0000, 0, 2'd0);
    probe("R8", 32'h2001_0000, 1, 2'd0);

    // R4 / R6: overlapping read-only region, unaligned base written
    wr_region(1, 32'h2000_0123, 8, 1, 8'h00, 2'd2, 0);
    probe("R3", 32'h2000_0100, 0, 2'd0);
    probe("R4", 32'h2000_0150, 0, 2'd1);
    probe("R6", 32'h2000_0150, 1, 2'd0);

    // R5: subregion 2 of region 1 removed, falls through to region 0
    wr_region(1, 32'h2000_0100, 8, 1, 8'h04, 2'd2, 0);
    probe("R5", 32'h2000_0150, 0, 2'd1);
    probe("R5", 32'h2000_0160, 0, 2'd1);

    // R7: execute-never
    wr_region(2, 32'h0000_0000, 12, 1, 8'h00, 2'd3, 1);
    probe("R7", 32'h0000_0400, 1, 2'd2);
    probe("R7", 32'h0000_0400, 1, 2'd3);
    probe("R7", 32'h0000_0400, 0, 2'd0);

    // R6: no access and privileged-only codes
    wr_region(3, 32'h3000_0000, 10, 1, 8'h00, 2'd0, 0);
    probe("R6", 32'h3000_0010, 1, 2'd0);
    wr_region(3, 32'h3000_0000, 10, 1, 8'h00, 2'd1, 0);
    probe("R6", 32'h3000_0010, 0, 2'd0);
    probe("R6", 32'h3000_0010, 1, 2'd1);

    // R3: size clamping at both ends
    wr_region(4, 32'h4000_0000, 2, 1, 8'h00, 2'd3, 0);
    probe("R3", 32'h4000_001F, 0, 2'd1);
    probe("R3", 32'h4000_0020, 1, 2'd1);
    wr_region(4, 32'h4000_0000, 40, 1, 8'h00, 2'd3, 0);
    probe("R3", 32'hFFFF_FFF0, 0, 2'd1);
    probe("R4", 32'h3000_0010, 0, 2'd0);

    // R10: disabling region 4 drops its matches
    wr_region(4, 32'h4000_0000, 40, 0, 8'h00, 2'd3, 0);
    probe("R10", 32'hFFFF_FFF0, 0, 2'd1);

    // R8: background map
    wr_ctl(1, 1);
    probe("R8", 32'h7000_0000, 1, 2'd1);
    probe("R8", 32'h7000_0000, 0, 2'd0);

    // R2: global disable overrides regions
    wr_ctl(0, 1);
    probe("R2", 32'h3000_0010, 0, 2'd0);
    probe("R2", 32'h0000_0400, 1, 2'd2);
    wr_ctl(1, 0);

    // R9: write and lookup in the same cycle
    @(negedge clk);
    apply_region(5, 32'h5000_0000, 12, 1, 8'h00, 2'd3, 0);
    probe("R9", 32'h5000_0040, 0, 2'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    commit_region(5, 32'h5000_0000, 12, 1, 8'h00, 2'd3, 0);
    probe("R9", 32'h5000_0040, 0, 2'd1);
    @(negedge clk);
    apply_region(5, 32'h5000_0000, 12, 0, 8'h00, 2'd3, 0);
    probe("R9", 32'h5000_0040, 0, 2'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    commit_region(5, 32'h5000_0000, 12, 0, 8'h00, 2'd3, 0);
    probe("R10", 32'h5000_0040, 0, 2'd1);

    // random rounds: R3 R4 R5 R6 R7 R8
    for (int round = 0; round < 12; round++) begin
      for (int i = 0; i < 8; i++) begin
        int s;
        s = ($urandom % 16 == 0) ? 32 : 5 + int'($urandom % 20);
        wr_region(i, $urandom, s, ($urandom % 8) != 0, 8'($urandom & $urandom),
                  2'($urandom), 1'($urandom));
      end
      wr_ctl(($urandom % 6) != 0, 1'($urandom));
      for (int n = 0; n < 300; n++) begin
        logic [31:0] a;
        int r;
        longint unsigned msk;
        r = int'($urandom % 8);
        msk = (64'd1 << m_size[r]) - 1;
        if ($urandom % 10 < 7)
          a = 32'((longint'(m_base[r]) & ~msk) | (longint'($urandom) & msk));
        else
          a = $urandom;
        @(negedge clk);
        probe("R4", a, 1'($urandom), 2'($urandom));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule